// File: doc/BRIEF.md
# PLL Clock Control Sequencer

This block is the digital controller wrapped around an external phase-locked loop. It owns the PLL setup register, which holds a 12-bit multiply code, a 4-bit post-divider code and a PLL-on bit. It decides, cycle by cycle, which source feeds the core clock and the clock output pin: the external input clock directly, the PLL-derived clock, or a parked level while the PLL is not locked. The analog loop and the glitch-free clock multiplexer sit outside the block. The block drives them with a source select, a core clock enable and a park level, and it takes back a raw lock flag.

At reset the block samples two strap pins. One decides whether the PLL starts enabled, and the other sets the level at which the clock output parks. Software can then rewrite the setup register at any time. A new multiply code drops lock and freezes the core until the loop settles again. A new divide code only changes the enable pattern, and lock is kept.

Top module: `pll_clkseq`

## Requirements
- R1: While `rst` is high, `strap_pll_en` and `strap_ckpol` are sampled on every clock edge, and the value held at the last reset edge is kept. Changes on either strap after reset have no effect on any output.
- R2: While the PLL-on bit is 0 (bypass): `lock_out` is 1, `clk_src` is 0 (external), and `core_ce` is 1 in every cycle.
- R3: A write with the PLL-on bit set (`wr_data[16]`=1) whose multiply code (`wr_data[11:0]`) differs from the stored one gives `lock_out`=0 and `clk_src`=2 (park) from the cycle after the write edge.
- R4: While `clk_src` is 2 (PLL enabled, not locked), `core_ce` stays 0.
- R5: After a lock loss, the loop counts as locked again only once the two-flop synchronised `pll_lock_in` has been seen low and then high. The switch happens on the third rising edge after `pll_lock_in` rises, and from then on `lock_out`=1 and `clk_src`=1 (PLL).
- R6: `park_lvl` always equals the clock-polarity strap value latched at reset. It is the level the clock output holds while parked.
- R7: With the PLL locked and divide code d (`wr_data[15:12]`), `core_ce` is 1 exactly in the cycles where the low d bits of a free-running 15-bit counter are zero. The counter is cleared by reset and steps once per clock, so the ratio is 2^d. A change of d takes effect from the cycle after the write edge, and lock is kept.
- R8: A write that changes the multiply code and the divide code together is handled as a multiply change. Lock drops, and the new ratio is seen only after relock.
- R9: A write with `wr_data[16]`=0 enters bypass from the next cycle. A write with `wr_data[16]`=1 made from bypass always starts a relock sequence.
- R10: Reset leaves the multiply code 0 (×1), the divide code 0 (÷1), and the PLL-on bit equal to the sampled strap. `pll_en` and `pll_mf` show the stored values.
- R11: If the synchronised lock falls while the PLL is locked, the block returns to park with `lock_out`=0 until relock.
- R12: A write with the PLL-on bit set that keeps the multiply code the same does not drop lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External input clock; every register runs on it |
| rst | input | 1 | Synchronous active-high reset; straps are sampled while it is high |
| strap_pll_en | input | 1 | Strap: PLL starts enabled when 1 |
| strap_ckpol | input | 1 | Strap: level of the parked clock output |
| wr_en | input | 1 | Setup register write strobe |
| wr_data | input | 17 | [16] PLL on, [15:12] divide code, [11:0] multiply code |
| pll_lock_in | input | 1 | Raw lock flag from the PLL, asynchronous |
| pll_en | output | 1 | Enable to the PLL |
| pll_mf | output | 12 | Multiply code to the PLL |
| clk_src | output | 2 | 0 external, 1 PLL, 2 parked |
| park_lvl | output | 1 | Level held on the clock output while parked |
| core_ce | output | 1 | Core clock enable (divided pattern) |
| lock_out | output | 1 | Lock pin; forced to 1 in bypass |

## Verification
The hardest cases to reach are a write that lands while the synchroniser still carries a stale high lock from before a multiply change, and a spontaneous lock loss in the middle of a divided enable period. A behavioural PLL model in the bench drops its lock the cycle after it sees a new multiply code and raises it again a fixed time later. The bench can also force an unexpected unlock while the PLL runs at a large divide ratio. Writes are issued back to back during acquisition as well, so the relock rule is exercised against a stale lock level.

// File: rtl/pll_clkseq_pkg.sv
package pll_clkseq_pkg;
    localparam int MF_W  = 12;
    localparam int DF_W  = 4;
    localparam int CNT_W = (1 << DF_W) - 1;
    localparam int REG_W = 1 + DF_W + MF_W;

    typedef struct packed {
        logic            pen;
        logic [DF_W-1:0] df;
        logic [MF_W-1:0] mf;
    } setup_reg_t;

    typedef enum logic [1:0] {
        SRC_EXT  = 2'd0,
        SRC_PLL  = 2'd1,
        SRC_PARK = 2'd2
    } clk_src_e;

    typedef enum logic [1:0] {
        SQ_BYPASS = 2'd0,
        SQ_DROP   = 2'd1,
        SQ_ACQ    = 2'd2,
        SQ_RUN    = 2'd3
    } seq_state_e;

    function automatic logic [CNT_W-1:0] ratio_mask(input logic [DF_W-1:0] d);
        return (CNT_W'(1) << d) - CNT_W'(1);
    endfunction
endpackage

// File: rtl/clkseq_setup.sv
module clkseq_setup
    import pll_clkseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       strap_pll_en,
    input  logic       strap_ckpol,
    input  logic       wr_en,
    input  setup_reg_t wr_val,
    output setup_reg_t cur,
    output logic       pol_q,
    output logic       mf_chg,
    output logic       pen_next
);
    assign mf_chg   = wr_en && (wr_val.mf != cur.mf);
    assign pen_next = wr_en ? wr_val.pen : cur.pen;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.pen <= strap_pll_en;
            cur.df  <= '0;
            cur.mf  <= '0;
            pol_q   <= strap_ckpol;
        end else if (wr_en) begin
            cur <= wr_val;
        end
    end

    // R1: polarity latch frozen outside reset
    assert_pol_frozen_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(pol_q));
    // R10: no write means no register change
    assert_reg_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cur));
endmodule

// File: rtl/clkseq_lock_sync.sv
module clkseq_lock_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic lock_raw,
    output logic lock_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], lock_raw};
    end

    assign lock_sync = chain[STAGES-1];
endmodule

// File: rtl/clkseq_divider.sv
module clkseq_divider
    import pll_clkseq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [DF_W-1:0] df,
    output logic            div_ce
);
    logic [CNT_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) phase <= '0;
        else     phase <= phase + CNT_W'(1);
    end

    assign div_ce = (phase & ratio_mask(df)) == '0;

    // R7: divide code 0 gives an enable in every cycle
    assert_div1_every_cycle_R7: assert property (@(posedge clk) disable iff (rst)
        (df == '0) |-> div_ce);
endmodule

// File: rtl/pll_clkseq.sv
module pll_clkseq
    import pll_clkseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        strap_pll_en,
    input  logic        strap_ckpol,
    input  logic        wr_en,
    input  logic [16:0] wr_data,
    input  logic        pll_lock_in,
    output logic        pll_en,
    output logic [11:0] pll_mf,
    output logic [1:0]  clk_src,
    output logic        park_lvl,
    output logic        core_ce,
    output logic        lock_out
);
    setup_reg_t cur;
    logic       pol_q, mf_chg, pen_next, lock_s, div_ce;
    seq_state_e st, st_nx;

    clkseq_setup u_setup (
        .clk(clk), .rst(rst),
        .strap_pll_en(strap_pll_en), .strap_ckpol(strap_ckpol),
        .wr_en(wr_en), .wr_val(setup_reg_t'(wr_data)),
        .cur(cur), .pol_q(pol_q), .mf_chg(mf_chg), .pen_next(pen_next)
    );

    clkseq_lock_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .lock_raw(pll_lock_in), .lock_sync(lock_s)
    );

    clkseq_divider u_div (
        .clk(clk), .rst(rst), .df(cur.df), .div_ce(div_ce)
    );

    always_comb begin
        st_nx = st;
        if (!pen_next) begin
            st_nx = SQ_BYPASS;
        end else if (st == SQ_BYPASS || mf_chg) begin
            st_nx = SQ_DROP;
        end else begin
            unique case (st)
                SQ_DROP: if (!lock_s) st_nx = SQ_ACQ;
                SQ_ACQ:  if (lock_s)  st_nx = SQ_RUN;
                SQ_RUN:  if (!lock_s) st_nx = SQ_DROP;
                default: st_nx = SQ_BYPASS;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= strap_pll_en ? SQ_DROP : SQ_BYPASS;
        else     st <= st_nx;
    end

    always_comb begin
        unique case (st)
            SQ_BYPASS: begin clk_src = SRC_EXT;  core_ce = 1'b1;   lock_out = 1'b1; end
            SQ_RUN:    begin clk_src = SRC_PLL;  core_ce = div_ce; lock_out = 1'b1; end
            default:   begin clk_src = SRC_PARK; core_ce = 1'b0;   lock_out = 1'b0; end
        endcase
    end

    assign pll_en   = cur.pen;
    assign pll_mf   = cur.mf;
    assign park_lvl = pol_q;

    // R3: an enabled multiply change drops lock on the next cycle
    assert_mf_drop_R3: assert property (@(posedge clk) disable iff (rst)
        (mf_chg && pen_next) |=> (!lock_out && clk_src == SRC_PARK));
    // R4: parked means no core enables
    assert_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        (clk_src == SRC_PARK) |-> !core_ce);
    // R2: bypass forces lock and a free-running core
    assert_bypass_R2: assert property (@(posedge clk) disable iff (rst)
        !pll_en |-> (lock_out && core_ce && clk_src == SRC_EXT));
    // R12: locked, same multiply code, lock still seen -> lock kept
    assert_keep_lock_R12: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_RUN && !mf_chg && pen_next && lock_s) |=> lock_out);
    // R9: disabling write enters bypass
    assert_disable_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[16]) |=> (clk_src == SRC_EXT));
endmodule

// File: tb/pll_clkseq_bench.sv
module pll_clkseq_bench;
    logic        clk = 1'b0, rst = 1'b1;
    logic        strap_pll_en = 1'b0, strap_ckpol = 1'b1;
    logic        wr_en = 1'b0;
    logic [16:0] wr_data = '0;
    logic        pll_lock_in = 1'b0;
    logic        pll_en, park_lvl, core_ce, lock_out;
    logic [11:0] pll_mf;
    logic [1:0]  clk_src;

    pll_clkseq u_pll_clkseq (
        .clk(clk), .rst(rst), .strap_pll_en(strap_pll_en), .strap_ckpol(strap_ckpol),
        .wr_en(wr_en), .wr_data(wr_data), .pll_lock_in(pll_lock_in),
        .pll_en(pll_en), .pll_mf(pll_mf), .clk_src(clk_src), .park_lvl(park_lvl),
        .core_ce(core_ce), .lock_out(lock_out)
    );

    always #10 clk = ~clk;

    int vectors = 0, miscompares = 0, cycles = 0;
    bit started = 0, done = 0;

    // reference model state: 0 bypass, 1 waiting low, 2 waiting high, 3 locked
    int m_st, m_mf, m_df, m_cnt;
    bit m_pen, m_pol, m_s1, m_s2;

    always @(posedge clk) begin
        if (rst) begin
            m_pen = strap_pll_en; m_pol = strap_ckpol;
            m_mf = 0; m_df = 0; m_cnt = 0; m_s1 = 0; m_s2 = 0;
            m_st = strap_pll_en ? 1 : 0;
        end else begin
            bit seen, chg, pen_n;
            seen  = m_s2;
            chg   = wr_en && (int'(wr_data[11:0]) != m_mf);
            pen_n = wr_en ? wr_data[16] : m_pen;
            if (!pen_n)                   m_st = 0;
            else if (m_st == 0 || chg)    m_st = 1;
            else if (m_st == 1 && !seen)  m_st = 2;
            else if (m_st == 2 && seen)   m_st = 3;
            else if (m_st == 3 && !seen)  m_st = 1;
            if (wr_en) begin
                m_pen = wr_data[16]; m_df = int'(wr_data[15:12]); m_mf = int'(wr_data[11:0]);
            end
            m_s2 = m_s1; m_s1 = pll_lock_in;
            m_cnt = (m_cnt + 1) % 32768;
        end
        started = 1;
    end

    task automatic cmp(input int act, input int exp, input string req, input string what);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (started && !done) begin
            int e_src; bit e_ce, e_lock;
            string rq_l, rq_c;
            e_src  = (m_st == 0) ? 0 : (m_st == 3) ? 1 : 2;
            e_lock = (m_st == 0 || m_st == 3);
            e_ce   = (m_st == 0) ? 1'b1 : (m_st == 3) ? ((m_cnt % (1 << m_df)) == 0) : 1'b0;
            rq_l = (m_st == 0) ? "R2" : (m_st == 3) ? "R5" : "R3";
            rq_c = (m_st == 0) ? "R2" : (m_st == 3) ? "R7" : "R4";
            cmp(int'(lock_out), int'(e_lock), rq_l, "lock_out");
            cmp(int'(clk_src),  e_src,        rq_l, "clk_src");
            cmp(int'(core_ce),  int'(e_ce),   rq_c, "core_ce");
            cmp(int'(park_lvl), int'(m_pol),  "R6", "park_lvl");
            cmp(int'(pll_en),   int'(m_pen),  "R9", "pll_en");
            cmp(int'(pll_mf),   m_mf,         "R10", "pll_mf");
        end
    end

    // behavioural PLL: loses lock on a new multiply code, regains it later
    localparam int LOCK_T = 12;
    int  p_cnt = 0;
    bit  p_en_q = 0, kick = 0;
    logic [11:0] p_mf_q = '0;
    always @(negedge clk) begin
        if (!pll_en) begin
            pll_lock_in <= 1'b0; p_cnt = 0;
        end else if (!p_en_q || pll_mf != p_mf_q || kick) begin
            pll_lock_in <= 1'b0; p_cnt = LOCK_T; kick = 0;
        end else if (p_cnt > 0) begin
            p_cnt--;
            if (p_cnt == 0) pll_lock_in <= 1'b1;
        end
        p_en_q = pll_en; p_mf_q = pll_mf;
    end

    task automatic wr(input bit pen, input int df, input int mf);
        @(negedge clk);
        wr_en <= 1'b1; wr_data <= {pen, 4'(df), 12'(mf)};
        @(negedge clk);
        wr_en <= 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        // R1/R10: reset with PLL off, polarity high
        idle(3);
        rst <= 1'b0;
        idle(5);
        strap_ckpol <= 1'b0; strap_pll_en <= 1'b1;   // R1: ignored after reset
        idle(5);
        wr(1, 0, 5);                                  // R9: enable from bypass
        idle(30);                                     // R5: relock
        wr(1, 2, 5);                                  // R7, R12: divide change keeps lock
        idle(20);
        wr(1, 15, 5);                                 // R7: largest ratio
        idle(40);
        kick = 1;                                     // R11: spontaneous loss
        idle(30);
        wr(1, 0, 5);
        idle(6);
        wr(1, 3, 9);                                  // R8: both fields together
        idle(3);
        wr(1, 1, 11);                                 // R3: change during acquisition
        idle(30);
        wr(0, 1, 11);                                 // R9: back to bypass
        idle(8);
        // second reset: PLL on, polarity low (R6)
        rst <= 1'b1; idle(3); rst <= 1'b0;
        idle(30);
        wr(1, 1, 0);                                  // R12: same multiply code
        idle(20);
        finish_run();
    end

    initial begin
        wait (cycles > 200000);
        miscompares++;
        $display("FAIL watchdog: actual %0d expected <200000 cycles", cycles);
        finish_run();
    end
endmodule